// File: doc/BRIEF.md
# Operand Address Sequencer

This block sits between instruction fetch and execute. When it accepts a 16-bit instruction word together with the address that word was fetched from, it works out where the operand governed by the addressing mode lives and what its value is. Instruction bits 11:9 hold a 3-bit mode. The two upper mode bits pick a base form: register, immediate, indexed or PC-relative. The lowest mode bit adds one level of memory indirection. The one exception is the immediate form, where setting that bit produces direct addressing instead.

The block reads the register file through a combinational read port, and it treats index 0 as the constant zero. All memory traffic goes through one word-wide read port with a request/ready handshake. The sequencer reads the extension word only for modes that need it. It then reads a pointer if the mode is indirect, and reads the operand last.

Program-control instructions take the resolved address as their result and skip the final operand read. A done pulse marks the cycle in which every result output is valid. The results stay stable until the next instruction is accepted.

Top module: `amode_seq`

## Requirements
- R1: The class is taken from instr[15:14]. For class 10 with instr[6]=0, the mode register is SRC instr[5:3]. For class 10 with instr[6]=1, and for classes 01 and 11, it is DST instr[2:0].
- R2: When register index 0 is selected it supplies zero, whatever the register file returns.
- R3: Mode 000 in classes 01/10 returns the register value as the operand, with is_reg=1, ea equal to the register index, and no memory access.
- R4: Mode 001 reads memory at the register value. The operand is the word read, and ea is the register value.
- R5: Mode 010 fetches W from pc_in+1. The operand is W and ea is pc_in+1.
- R6: Mode 011 fetches W and then reads memory at W. The operand is M[W] and ea is W.
- R7: Mode 100 reads memory at register+W. Mode 101 first reads a pointer at register+W and then reads the operand at that pointer. In both cases ea is the address of the final read.
- R8: Mode 110 reads memory at pc_in+2+W. Mode 111 reads a pointer there and then reads the operand through it.
- R9: W is fetched, from pc_in+1, only when mode[2:1]!=00. pc_next is pc_in+2 when W is fetched and pc_in+1 otherwise. The total number of memory reads matches the mode.
- R10: For class 11, ea is the resolved target, operand is 0, and no operand read is made. Modes 010 and 011 both give W, and the indirect modes read only the pointer.
- R11: Class 11 with mode 000 finishes with illegal=1, ea=0, operand=0 and no memory access.
- R12: Class 00 finishes on the cycle after acceptance, with no memory access, pc_next=pc_in+1, and ea and operand both 0.
- R13: While mem_ready is low, mem_req and mem_addr are held. done is high for exactly one cycle per accepted instruction and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept instr/pc_in when idle |
| instr | input | WORD_W | Instruction word |
| pc_in | input | WORD_W | Address of the instruction word |
| rf_addr | output | RIDX_W | Register file read index |
| rf_data | input | WORD_W | Register file read data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | WORD_W | Memory read address |
| mem_rdata | input | WORD_W | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory read completes this cycle |
| ea | output | WORD_W | Effective address (register index in mode 000) |
| operand | output | WORD_W | Operand value |
| is_reg | output | 1 | Operand came straight from a register |
| pc_next | output | WORD_W | PC after the optional extension word |
| done | output | 1 | One-cycle result-valid pulse |
| illegal | output | 1 | Register mode used with the program-control class |

## Verification
The bench runs every mode in every class, with the S bit both set and clear, and with index 0 both as SRC and as DST. It varies the memory latency between zero and two wait cycles. A design that picks the wrong field for the S bit, or lets register 0 pass through, returns a value derived from another register. Relative modes are checked against pc+2 rather than pc+1, and a one-word error shows up as an operand read from the wrong location. Per-instruction read counts expose three kinds of mistake: an extension fetch in register modes, a missing pointer read, and an operand read issued for program-control targets. A request that drops or changes address during a wait is flagged by a hold monitor.

// File: rtl/amode_pkg.sv
package amode_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCHW,
    ST_PTR,
    ST_OPRD,
    ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    CLS_NONE = 2'b00,
    CLS_ONE  = 2'b01,
    CLS_TWO  = 2'b10,
    CLS_CTRL = 2'b11
  } iclass_t;

  typedef enum logic [1:0] {
    BASE_REG = 2'b00,
    BASE_IMM = 2'b01,
    BASE_IDX = 2'b10,
    BASE_REL = 2'b11
  } base_t;

  // the extension word exists for every base form except register
  function automatic logic mode_needs_w(input logic [2:0] md);
    return md[2:1] != BASE_REG;
  endfunction

  // a pointer read is needed when the indirect bit is set on a form that
  // already names a memory location (immediate+indirect means direct)
  function automatic logic mode_needs_ptr(input logic [2:0] md);
    return md[0] && (md[2:1] == BASE_IDX || md[2:1] == BASE_REL);
  endfunction

  // immediate form without indirection: W itself is the value
  function automatic logic mode_is_imm(input logic [2:0] md);
    return md == {BASE_IMM, 1'b0};
  endfunction

endpackage

// File: rtl/amode_decode.sv
module amode_decode
  import amode_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int RIDX_W = 3
) (
  input  logic [WORD_W-1:0] instr,
  output iclass_t           cls,
  output logic [2:0]        md,
  output logic [RIDX_W-1:0] ridx,
  output logic              is_none,
  output logic              is_ctrl,
  output logic              bad_mode,
  output logic              reg_direct,
  output logic              needs_w
);
  localparam int CLS_LSB  = 14;
  localparam int MODE_LSB = 9;
  localparam int SWAP_BIT = 6;
  localparam int SRC_LSB  = 3;
  localparam int DST_LSB  = 0;

  logic swap;

  always_comb begin
    cls     = iclass_t'(instr[CLS_LSB +: 2]);
    md      = instr[MODE_LSB +: 3];
    swap    = instr[SWAP_BIT];
    // two-operand with S clear puts the mode on the source register
    if (cls == CLS_TWO && !swap)
      ridx = instr[SRC_LSB +: RIDX_W];
    else
      ridx = instr[DST_LSB +: RIDX_W];
    is_none    = cls == CLS_NONE;
    is_ctrl    = cls == CLS_CTRL;
    bad_mode   = is_ctrl && md == 3'b000;
    reg_direct = !is_none && !is_ctrl && md == 3'b000;
    needs_w    = !is_none && mode_needs_w(md);
  end

endmodule

// File: rtl/amode_agen.sv
module amode_agen
  import amode_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [2:0]        md,
  input  logic [WORD_W-1:0] reg_val,
  input  logic [WORD_W-1:0] pc_after_w,
  input  logic [WORD_W-1:0] wval,
  output logic [WORD_W-1:0] addr
);
  always_comb begin
    unique case (base_t'(md[2:1]))
      BASE_REG: addr = reg_val;
      BASE_IMM: addr = wval;
      BASE_IDX: addr = reg_val + wval;
      BASE_REL: addr = pc_after_w + wval;
      default:  addr = reg_val;
    endcase
  end

endmodule

// File: rtl/amode_seq.sv
module amode_seq
  import amode_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int RIDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] pc_in,
  output logic [RIDX_W-1:0] rf_addr,
  input  logic [WORD_W-1:0] rf_data,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [WORD_W-1:0] ea,
  output logic [WORD_W-1:0] operand,
  output logic              is_reg,
  output logic [WORD_W-1:0] pc_next,
  output logic              done,
  output logic              illegal
);
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);
  localparam logic [WORD_W-1:0] TWO = WORD_W'(2);

  seq_state_t state;

  iclass_t           d_cls;
  logic [2:0]        d_md;
  logic [RIDX_W-1:0] d_ridx;
  logic              d_none, d_ctrl, d_bad, d_regdir, d_needw;

  amode_decode #(.WORD_W(WORD_W), .RIDX_W(RIDX_W)) u_dec (
    .instr      (instr),
    .cls        (d_cls),
    .md         (d_md),
    .ridx       (d_ridx),
    .is_none    (d_none),
    .is_ctrl    (d_ctrl),
    .bad_mode   (d_bad),
    .reg_direct (d_regdir),
    .needs_w    (d_needw)
  );

  assign rf_addr = d_ridx;

  // index zero is the constant-zero register
  logic [WORD_W-1:0] reg_val;
  assign reg_val = (d_ridx == '0) ? '0 : rf_data;

  logic [2:0]        md_q;
  logic              ctrl_q;
  logic [WORD_W-1:0] base_q, pc_q, addr_q;

  logic [WORD_W-1:0] gen_addr;
  amode_agen #(.WORD_W(WORD_W)) u_agen (
    .md         (md_q),
    .reg_val    (base_q),
    .pc_after_w (pc_q + TWO),
    .wval       (mem_rdata),
    .addr       (gen_addr)
  );

  // named events
  logic accept, mem_fire, w_fire, ptr_fire, op_fire;
  assign accept   = start && state == ST_IDLE;
  assign mem_req  = state == ST_FETCHW || state == ST_PTR || state == ST_OPRD;
  assign mem_addr = addr_q;
  assign mem_fire = mem_req && mem_ready;
  assign w_fire   = mem_fire && state == ST_FETCHW;
  assign ptr_fire = mem_fire && state == ST_PTR;
  assign op_fire  = mem_fire && state == ST_OPRD;
  assign done     = state == ST_DONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      md_q    <= '0;
      ctrl_q  <= 1'b0;
      base_q  <= '0;
      pc_q    <= '0;
      addr_q  <= '0;
      ea      <= '0;
      operand <= '0;
      is_reg  <= 1'b0;
      pc_next <= '0;
      illegal <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          md_q    <= d_md;
          ctrl_q  <= d_ctrl;
          base_q  <= reg_val;
          pc_q    <= pc_in;
          ea      <= '0;
          operand <= '0;
          is_reg  <= 1'b0;
          illegal <= 1'b0;
          pc_next <= d_needw ? pc_in + TWO : pc_in + ONE;
          if (d_none) begin
            state <= ST_DONE;
          end else if (d_bad) begin
            illegal <= 1'b1;
            state   <= ST_DONE;
          end else if (d_regdir) begin
            operand <= reg_val;
            ea      <= WORD_W'(d_ridx);
            is_reg  <= 1'b1;
            state   <= ST_DONE;
          end else if (!d_needw) begin
            // register indirect
            if (d_ctrl) begin
              ea    <= reg_val;
              state <= ST_DONE;
            end else begin
              addr_q <= reg_val;
              state  <= ST_OPRD;
            end
          end else begin
            addr_q <= pc_in + ONE;
            state  <= ST_FETCHW;
          end
        end
        ST_FETCHW: if (w_fire) begin
          if (mode_is_imm(md_q)) begin
            if (ctrl_q) ea <= mem_rdata;
            else begin
              operand <= mem_rdata;
              ea      <= addr_q;
            end
            state <= ST_DONE;
          end else if (mode_needs_ptr(md_q)) begin
            addr_q <= gen_addr;
            state  <= ST_PTR;
          end else if (ctrl_q) begin
            ea    <= gen_addr;
            state <= ST_DONE;
          end else begin
            addr_q <= gen_addr;
            state  <= ST_OPRD;
          end
        end
        ST_PTR: if (ptr_fire) begin
          if (ctrl_q) begin
            ea    <= mem_rdata;
            state <= ST_DONE;
          end else begin
            addr_q <= mem_rdata;
            state  <= ST_OPRD;
          end
        end
        ST_OPRD: if (op_fire) begin
          operand <= mem_rdata;
          ea      <= addr_q;
          state   <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R13
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr)); // R13
  AST_ILLEGAL_NOMEM: assert property (@(posedge clk) disable iff (!rst_n)
    accept && d_bad |=> done && illegal && !mem_req); // R11
  AST_REGMODE_NOMEM: assert property (@(posedge clk) disable iff (!rst_n)
    accept && d_regdir |=> done && is_reg && !mem_req); // R3
  AST_WFETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    accept && d_needw |=> mem_req && mem_addr == $past(pc_in) + ONE); // R9
  AST_NONE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    accept && d_none |=> done && !mem_req && pc_next == $past(pc_in) + ONE); // R12

endmodule

// File: tb/amode_seq_test.sv
module amode_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0, pc_in = '0;
  logic [2:0]  rf_addr;
  logic [15:0] rf_data;
  logic        mem_req, mem_ready;
  logic [15:0] mem_addr, mem_rdata;
  logic [15:0] ea, operand, pc_next;
  logic        is_reg, done, illegal;

  always #(CLK_PERIOD/2) clk = ~clk;

  amode_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_in(pc_in),
    .rf_addr(rf_addr), .rf_data(rf_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .ea(ea), .operand(operand), .is_reg(is_reg), .pc_next(pc_next),
    .done(done), .illegal(illegal)
  );

  int checks = 0, bad = 0;
  int total_reads = 0, base_reads = 0, hold_bad = 0, dbl_done = 0, done_cnt = 0;

  function automatic logic [15:0] mword(input logic [15:0] a);
    return (a * 16'd37) ^ 16'hC3A5;
  endfunction
  function automatic logic [15:0] rword(input logic [2:0] i);
    return 16'h0400 + {13'd0, i} * 16'h0123;
  endfunction

  assign rf_data = rword(rf_addr);

  // memory model with 0..2 wait cycles, rotating
  int wait_cnt = 0, lat = 0;
  assign mem_ready = mem_req && (wait_cnt == lat);
  assign mem_rdata = mword(mem_addr);

  logic        prev_wait = 1'b0, prev_done = 1'b0;
  logic [15:0] prev_addr = '0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_req) begin
        if (mem_ready) begin
          wait_cnt    <= 0;
          lat         <= (lat == 2) ? 0 : lat + 1;
          total_reads <= total_reads + 1;
        end else wait_cnt <= wait_cnt + 1;
      end
      if (prev_wait && (!mem_req || mem_addr != prev_addr)) hold_bad <= hold_bad + 1;
      prev_wait <= mem_req && !mem_ready;
      prev_addr <= mem_addr;
    end
  end

  typedef struct {
    logic [15:0] ea, op, pcn;
    logic        isr, ill;
    int          reads;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // expected results restated from the requirements
  function automatic exp_t model(input logic [15:0] ins, input logic [15:0] pc, input string tag);
    exp_t e;
    logic [1:0]  c;
    logic [2:0]  m, r;
    logic [15:0] rv, w, a;
    logic        ctl;
    c = ins[15:14]; m = ins[11:9];
    r = (c == 2'b10 && ins[6] == 1'b0) ? ins[5:3] : ins[2:0];
    rv = (r == 3'd0) ? 16'd0 : rword(r);
    ctl = (c == 2'b11);
    e.ea = 0; e.op = 0; e.isr = 0; e.ill = 0; e.reads = 0; e.pcn = pc + 1; e.tag = tag;
    if (c == 2'b00) return e;
    if (ctl && m == 3'd0) begin e.ill = 1; return e; end
    if (m == 3'd0) begin e.op = rv; e.isr = 1; e.ea = {13'd0, r}; return e; end
    if (m == 3'd1) begin
      if (ctl) e.ea = rv;
      else begin e.ea = rv; e.op = mword(rv); e.reads = 1; end
      return e;
    end
    w = mword(pc + 1); e.reads = 1; e.pcn = pc + 2;
    if (m == 3'd2) begin
      if (ctl) e.ea = w; else begin e.op = w; e.ea = pc + 1; end
      return e;
    end
    if (m == 3'd3) a = w;
    else if (m[2:1] == 2'b10) a = rv + w;
    else a = pc + 2 + w;
    if (m == 3'd5 || m == 3'd7) begin a = mword(a); e.reads++; end
    e.ea = a;
    if (!ctl) begin e.op = mword(a); e.reads++; end
    return e;
  endfunction

  // monitor: pops and compares on every done
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) dbl_done++;
      prev_done <= done;
      if (done) begin
        exp_t e;
        int got_reads;
        done_cnt++;
        got_reads = total_reads - base_reads;
        base_reads = total_reads;
        if (sb.size() == 0) begin
          checks++; bad++;
          $display("FAIL R13: done with no pending instruction, got 1 expected 0");
        end else begin
          e = sb.pop_front();
          checks++;
          if (ea !== e.ea || operand !== e.op || pc_next !== e.pcn || is_reg !== e.isr || illegal !== e.ill) begin
            bad++;
            $display("FAIL %s: ea=%h op=%h pcn=%h isr=%b ill=%b expected ea=%h op=%h pcn=%h isr=%b ill=%b",
              e.tag, ea, operand, pc_next, is_reg, illegal, e.ea, e.op, e.pcn, e.isr, e.ill);
          end
          checks++;
          if (got_reads != e.reads) begin
            bad++;
            $display("FAIL R9 (%s): reads=%0d expected %0d", e.tag, got_reads, e.reads);
          end
        end
      end
    end
  end

  task automatic run_op(input logic [15:0] ins, input logic [15:0] pc, input string tag);
    sb.push_back(model(ins, pc, tag));
    @(negedge clk);
    start = 1'b1; instr = ins; pc_in = pc;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic string mode_tag(input logic [1:0] c, input logic [2:0] m);
    if (c == 2'b00) return "R12";
    if (c == 2'b11) return (m == 3'd0) ? "R11" : "R10";
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4, 3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic finish_run();
    checks++;
    if (hold_bad != 0) begin
      bad++;
      $display("FAIL R13: request/address dropped during wait %0d times, expected 0", hold_bad);
    end
    checks++;
    if (dbl_done != 0) begin
      bad++;
      $display("FAIL R13: done high two cycles in a row %0d times, expected 0", dbl_done);
    end
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || mem_req !== 1'b0) begin
      bad++;
      $display("FAIL R13: after reset done=%b mem_req=%b expected 0 0", done, mem_req);
    end
    for (int c = 0; c < 4; c++) begin
      for (int m = 0; m < 8; m++) begin
        for (int s = 0; s < 2; s++) begin
          for (int v = 0; v < 2; v++) begin
            logic [2:0]  src, dst, rsel;
            logic [15:0] ins;
            string       tag;
            src  = v ? 3'd0 : 3'd6;
            dst  = v ? 3'd5 : 3'd0;
            ins  = {c[1:0], 2'b10, m[2:0], 2'b01, s[0], src, dst};
            rsel = (c == 2 && s == 0) ? src : dst;
            if (c != 0 && !(c == 3 && m == 0) && rsel == 3'd0 && m[2:1] != 2'b01 && m[2:1] != 2'b11)
              tag = "R2";
            else if (c == 2)
              tag = "R1";
            else
              tag = mode_tag(c[1:0], m[2:0]);
            run_op(ins, 16'h0100 + 16'(n * 4), tag);
            n++;
          end
        end
      end
    end
    repeat (3) @(negedge clk);
    checks++;
    if (done_cnt != n || sb.size() != 0) begin
      bad++;
      $display("FAIL R13: done pulses=%0d expected %0d", done_cnt, n);
    end
    finish_run();
  end

endmodule